// File: doc/BRIEF.md
# Rotate and Bit Manipulation Unit

This combinational datapath block handles the rotate, single-bit and bit-search instructions of a 16-bit integer pipeline. The operation select picks one of ten operations. The unit then works on one operand, a count or bit index, and the incoming carry. It returns a result word, an updated carry and a zero indication that only the scan operations use.

The block has four rotate operations. Two of them rotate the operand on its own. The other two rotate the operand together with the carry as one 17-bit quantity, with the carry as the top bit. The four bit operations copy one chosen bit into the carry, and three of them also write that bit. The two scans give the position of the lowest or the highest set bit. When a scan finds no set bit, the result is the value present on the destination input, so the destination register in the register file keeps its old contents.

Top module: `rbm_unit`

## Requirements
- R1: Operation code 0 rotates the operand left by the count modulo 16. The bit that leaves the MSB re-enters at the LSB. The carry output equals the last bit rotated out, which is the new LSB.
- R2: Operation code 1 rotates the operand right by the count modulo 16. The carry output equals the last bit rotated out, which is the new MSB.
- R3: Operation code 2 rotates the 17-bit value {carry, operand} left by the count modulo 17. The top bit of the outcome is the new carry. Operand 0x4020 with carry 1 and count 5 gives result 0x0414 and carry 0.
- R4: Operation code 3 rotates the 17-bit value {carry, operand} right by the count modulo 17. The top bit of the outcome is the new carry.
- R5: A rotation whose reduced count is zero returns the operand unchanged and the carry input unchanged. For codes 0 and 1 this covers counts 0 and 16. For codes 2 and 3 it covers counts 0 and 17.
- R6: Operation code 4 copies operand bit (count modulo 16) to the carry output and returns the operand unchanged.
- R7: Operation codes 5, 6 and 7 copy the selected bit (count modulo 16) to the carry output. They return the operand with that bit set (code 5), cleared (code 6) or inverted (code 7). All other bits are unchanged.
- R8: Operation code 8 on a nonzero operand returns the index of the lowest set bit, zero-extended, with zero output 0.
- R9: Operation code 9 on a nonzero operand returns the index of the highest set bit, zero-extended, with zero output 0.
- R10: Codes 8 and 9 on a zero operand drive the zero output to 1 and return the destination input as the result. Both scans pass the carry input through unchanged.
- R11: Codes 10 to 15 return the operand, pass the carry through and drive the zero output to 0. The zero output is 0 for every operation other than codes 8 and 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation select (codes 0 to 15) |
| opnd_i | input | 16 | Operand word |
| dst_i | input | 16 | Current destination value, returned by a scan of a zero operand |
| cnt_i | input | 5 | Rotate count or bit index |
| carry_i | input | 1 | Carry flag in |
| res_o | output | 16 | Result word |
| carry_o | output | 1 | Carry flag out |
| zero_o | output | 1 | Scan found no set bit |

## Verification
The rotations are driven with single-bit walking patterns, where a wrong direction or a wrong wrap point moves the bit to a visibly wrong position. They are also driven with asymmetric words such as 0x8001 and 0x4020 at every count from 0 to 31, which separates modulo-16 from modulo-17 reduction and exposes a carry taken from the wrong end.

The bit operations are driven at all sixteen indices and at indices above 15, on both all-ones and all-zero operands, so a set, clear or invert that lands on the wrong bit shows up. The scans are driven with words that have two set bits far apart, which tells the forward scan from the reverse scan. A zero operand is scanned with a distinctive destination value to confirm that the destination is returned.

// File: rtl/rbm_pkg.sv
package rbm_pkg;
  typedef enum logic [3:0] {
    OP_ROL = 4'd0,
    OP_ROR = 4'd1,
    OP_RCL = 4'd2,
    OP_RCR = 4'd3,
    OP_BT  = 4'd4,
    OP_BTS = 4'd5,
    OP_BTR = 4'd6,
    OP_BTC = 4'd7,
    OP_SCF = 4'd8,
    OP_SCR = 4'd9
  } rbm_op_e;

  localparam logic [1:0] BM_KEEP = 2'd0;
  localparam logic [1:0] BM_SET  = 2'd1;
  localparam logic [1:0] BM_CLR  = 2'd2;
  localparam logic [1:0] BM_INV  = 2'd3;
endpackage

// File: rtl/rbm_rot.sv
module rbm_rot #(
  parameter int WIDTH = 16,
  parameter int AMT_W = 4
) (
  input  logic [WIDTH-1:0] val_i,
  input  logic [AMT_W-1:0] amt_i,
  input  logic             left_i,
  output logic [WIDTH-1:0] val_o
);
  logic [2*WIDTH-1:0] dbl, shl, shr;

  always_comb begin
    dbl   = {val_i, val_i};
    shl   = dbl << amt_i;
    shr   = dbl >> amt_i;
    val_o = left_i ? shl[2*WIDTH-1:WIDTH] : shr[WIDTH-1:0];
  end
endmodule

// File: rtl/rbm_bitop.sv
module rbm_bitop import rbm_pkg::*; #(
  parameter int WIDTH = 16,
  localparam int IDX_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] val_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [1:0]       mode_i,
  output logic [WIDTH-1:0] val_o,
  output logic             bit_o
);
  logic [WIDTH-1:0] mask;

  always_comb begin
    mask  = WIDTH'(1) << idx_i;
    bit_o = val_i[idx_i];
    unique case (mode_i)
      BM_SET:  val_o = val_i | mask;
      BM_CLR:  val_o = val_i & ~mask;
      BM_INV:  val_o = val_i ^ mask;
      default: val_o = val_i;
    endcase
  end
endmodule

// File: rtl/rbm_scan.sv
module rbm_scan #(
  parameter int WIDTH    = 16,
  parameter bit FROM_MSB = 1'b0,
  localparam int IDX_W   = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] val_i,
  output logic [IDX_W-1:0] idx_o
);
  generate
    if (FROM_MSB) begin : g_rev
      always_comb begin
        idx_o = '0;
        for (int i = 0; i < WIDTH; i++)
          if (val_i[i]) idx_o = IDX_W'(i);
      end
    end else begin : g_fwd
      always_comb begin
        idx_o = '0;
        for (int i = WIDTH - 1; i >= 0; i--)
          if (val_i[i]) idx_o = IDX_W'(i);
      end
    end
  endgenerate
endmodule

// File: rtl/rbm_unit.sv
module rbm_unit import rbm_pkg::*; #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 5,
  localparam int IDX_W = $clog2(DATA_W),
  localparam int RC_W  = $clog2(DATA_W + 1)
) (
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] res_o,
  output logic              carry_o,
  output logic              zero_o
);
  logic [IDX_W-1:0]  plain_amt;
  logic [RC_W-1:0]   rc_amt;
  logic [DATA_W-1:0] plain_rot;
  logic [DATA_W:0]   rc_rot;
  logic              plain_c;
  logic [DATA_W-1:0] bit_val;
  logic              bit_c;
  logic [IDX_W-1:0]  scan_idx [2];
  logic              any_set;

  always_comb begin
    plain_amt = IDX_W'(cnt_i % DATA_W);
    rc_amt    = RC_W'(cnt_i % (DATA_W + 1));
    any_set   = |opnd_i;
  end

  rbm_rot #(.WIDTH(DATA_W), .AMT_W(IDX_W)) i_plain_rot (
    .val_i (opnd_i),
    .amt_i (plain_amt),
    .left_i(op_i == OP_ROL),
    .val_o (plain_rot)
  );

  rbm_rot #(.WIDTH(DATA_W + 1), .AMT_W(RC_W)) i_rc_rot (
    .val_i ({carry_i, opnd_i}),
    .amt_i (rc_amt),
    .left_i(op_i == OP_RCL),
    .val_o (rc_rot)
  );

  rbm_bitop #(.WIDTH(DATA_W)) i_bitop (
    .val_i (opnd_i),
    .idx_i (cnt_i[IDX_W-1:0]),
    .mode_i(op_i[1:0]),
    .val_o (bit_val),
    .bit_o (bit_c)
  );

  for (genvar d = 0; d < 2; d++) begin : g_scan
    rbm_scan #(.WIDTH(DATA_W), .FROM_MSB(d != 0)) i_scan (
      .val_i(opnd_i),
      .idx_o(scan_idx[d])
    );
  end

  always_comb begin
    if (plain_amt == '0)
      plain_c = carry_i;
    else if (op_i == OP_ROL)
      plain_c = plain_rot[0];
    else
      plain_c = plain_rot[DATA_W-1];
  end

  always_comb begin
    res_o   = opnd_i;
    carry_o = carry_i;
    zero_o  = 1'b0;
    case (op_i)
      OP_ROL, OP_ROR: begin
        res_o   = plain_rot;
        carry_o = plain_c;
      end
      OP_RCL, OP_RCR: begin
        res_o   = rc_rot[DATA_W-1:0];
        carry_o = rc_rot[DATA_W];
      end
      OP_BT, OP_BTS, OP_BTR, OP_BTC: begin
        res_o   = bit_val;
        carry_o = bit_c;
      end
      OP_SCF, OP_SCR: begin
        zero_o = !any_set;
        if (any_set)
          res_o = DATA_W'(scan_idx[op_i == OP_SCR]);
        else
          res_o = dst_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/rbm_unit_chk.sv
module rbm_unit_chk #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 5,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input logic [3:0]        op_i,
  input logic [DATA_W-1:0] opnd_i,
  input logic [DATA_W-1:0] dst_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic              carry_i,
  input logic [DATA_W-1:0] res_o,
  input logic              carry_o,
  input logic              zero_o
);
  logic [DATA_W-1:0] sel_mask;
  logic              is_scan;

  always_comb begin
    sel_mask = DATA_W'(1) << cnt_i[IDX_W-1:0];
    is_scan  = (op_i == 4'd8) || (op_i == 4'd9);

    if (op_i == 4'd0 || op_i == 4'd1)
      p_rot_ones_r1: assert ($countones(res_o) == $countones(opnd_i));
    if (op_i == 4'd2 || op_i == 4'd3)
      p_rc_ones_r3: assert ($countones({carry_o, res_o}) == $countones({carry_i, opnd_i}));
    if (op_i >= 4'd4 && op_i <= 4'd7)
      p_bit_carry_r6: assert (carry_o == opnd_i[cnt_i[IDX_W-1:0]]);
    if (op_i == 4'd4)
      p_bt_keep_r6: assert (res_o == opnd_i);
    if (op_i >= 4'd5 && op_i <= 4'd7)
      p_bit_only_r7: assert (((res_o ^ opnd_i) & ~sel_mask) == '0);
    if (is_scan && opnd_i != '0)
      p_scan_hit_r8: assert (opnd_i[res_o[IDX_W-1:0]] && (res_o >> IDX_W) == '0);
    if (is_scan)
      p_scan_zero_r10: assert (zero_o == (opnd_i == '0) && carry_o == carry_i);
    if (is_scan && opnd_i == '0)
      p_scan_dst_r10: assert (res_o == dst_i);
    if (!is_scan)
      p_no_zero_r11: assert (!zero_o);
    if (op_i >= 4'd10)
      p_pass_r11: assert (res_o == opnd_i && carry_o == carry_i);
  end
endmodule

bind rbm_unit rbm_unit_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_rbm_unit_chk (
  .op_i   (op_i),
  .opnd_i (opnd_i),
  .dst_i  (dst_i),
  .cnt_i  (cnt_i),
  .carry_i(carry_i),
  .res_o  (res_o),
  .carry_o(carry_o),
  .zero_o (zero_o)
);

// File: tb/test_rbm_unit.sv
`timescale 1ns/1ps
module test_rbm_unit;
  logic        clk;
  logic        rst_n;
  logic [3:0]  op;
  logic [15:0] opnd, dst;
  logic [4:0]  cnt;
  logic        cin;
  logic [15:0] res;
  logic        cout, zero;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  rbm_unit i_rbm_unit (
    .op_i(op), .opnd_i(opnd), .dst_i(dst), .cnt_i(cnt), .carry_i(cin),
    .res_o(res), .carry_o(cout), .zero_o(zero)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [17:0] model(input logic [3:0] o, input logic [15:0] a,
                                        input logic [15:0] d, input logic [4:0] n,
                                        input logic c);
    logic [15:0] r;
    logic cy, z;
    int k;
    r = a; cy = c; z = 1'b0;
    case (o)
      4'd0: begin k = n % 16; for (int s = 0; s < k; s++) begin cy = r[15]; r = {r[14:0], r[15]}; end end
      4'd1: begin k = n % 16; for (int s = 0; s < k; s++) begin cy = r[0]; r = {r[0], r[15:1]}; end end
      4'd2: begin k = n % 17; for (int s = 0; s < k; s++) {cy, r} = {r, cy}; end
      4'd3: begin k = n % 17; for (int s = 0; s < k; s++) {cy, r} = {r[0], cy, r[15:1]}; end
      4'd4, 4'd5, 4'd6, 4'd7: begin
        k = n % 16;
        cy = a[k];
        if (o == 4'd5) r[k] = 1'b1;
        if (o == 4'd6) r[k] = 1'b0;
        if (o == 4'd7) r[k] = ~a[k];
      end
      4'd8, 4'd9: begin
        if (a == 16'h0) begin r = d; z = 1'b1; end
        else if (o == 4'd8) begin
          k = 0; while (!a[k]) k++; r = 16'(k);
        end else begin
          k = 15; while (!a[k]) k--; r = 16'(k);
        end
      end
      default: ;
    endcase
    return {z, cy, r};
  endfunction

  task automatic drive_expect(input logic [3:0] o, input logic [15:0] a, input logic [15:0] d,
                              input logic [4:0] n, input logic c, input logic [17:0] exp,
                              input string tag);
    @(negedge clk);
    op = o; opnd = a; dst = d; cnt = n; cin = c;
    #5;
    checks++;
    if ({zero, cout, res} !== exp) begin
      errors++;
      $display("FAIL %s op=%0d a=%h n=%0d c=%b: got z=%b c=%b r=%h exp z=%b c=%b r=%h",
               tag, o, a, n, c, zero, cout, res, exp[17], exp[16], exp[15:0]);
    end
  endtask

  task automatic run(input logic [3:0] o, input logic [15:0] a, input logic [15:0] d,
                     input logic [4:0] n, input logic c, input string tag);
    drive_expect(o, a, d, n, c, model(o, a, d, n, c), tag);
  endtask

  task automatic t_idle();
    drive_expect(4'd0, 16'h0, 16'h0, 5'd0, 1'b0, 18'h0, "R5 idle");
  endtask

  task automatic t_plain_rot();
    for (int n = 0; n < 32; n++) begin
      run(4'd0, 16'h8001, 16'h0, 5'(n), 1'b0, "R1 rol");
      run(4'd0, 16'h0001 << (n % 16), 16'h0, 5'(n), 1'b1, "R1 rol walk");
      run(4'd1, 16'h8001, 16'h0, 5'(n), 1'b1, "R2 ror");
      run(4'd1, 16'h4020, 16'h0, 5'(n), 1'b0, "R2 ror");
    end
  endtask

  task automatic t_carry_rot();
    drive_expect(4'd2, 16'h4020, 16'h0, 5'd5, 1'b1, {1'b0, 1'b0, 16'h0414}, "R3 example");
    for (int n = 0; n < 32; n++) begin
      run(4'd2, 16'h4020, 16'h0, 5'(n), 1'b1, "R3 rcl");
      run(4'd2, 16'h8000, 16'h0, 5'(n), 1'b0, "R3 rcl");
      run(4'd3, 16'h4020, 16'h0, 5'(n), 1'b1, "R4 rcr");
      run(4'd3, 16'h0001, 16'h0, 5'(n), 1'b0, "R4 rcr");
    end
  endtask

  task automatic t_zero_count();
    drive_expect(4'd0, 16'h1234, 16'h0, 5'd16, 1'b1, {2'b01, 16'h1234}, "R5 rol16");
    drive_expect(4'd1, 16'h1234, 16'h0, 5'd0,  1'b0, {2'b00, 16'h1234}, "R5 ror0");
    drive_expect(4'd2, 16'hABCD, 16'h0, 5'd17, 1'b1, {2'b01, 16'hABCD}, "R5 rcl17");
    drive_expect(4'd3, 16'hABCD, 16'h0, 5'd0,  1'b0, {2'b00, 16'hABCD}, "R5 rcr0");
  endtask

  task automatic t_bit_ops();
    for (int n = 0; n < 32; n++) begin
      run(4'd4, 16'hA5C3, 16'h0, 5'(n), 1'b0, "R6 bt");
      run(4'd5, 16'h0000, 16'h0, 5'(n), 1'b1, "R7 bts");
      run(4'd6, 16'hFFFF, 16'h0, 5'(n), 1'b0, "R7 btr");
      run(4'd7, 16'h5A3C, 16'h0, 5'(n), 1'b1, "R7 btc");
    end
    drive_expect(4'd7, 16'h0000, 16'h0, 5'd19, 1'b1, {2'b00, 16'h0008}, "R7 btc idx19");
  endtask

  task automatic t_scans();
    drive_expect(4'd8, 16'h8010, 16'hFFFF, 5'd0, 1'b1, {2'b01, 16'd4},  "R8 fwd");
    drive_expect(4'd9, 16'h8010, 16'hFFFF, 5'd0, 1'b0, {2'b00, 16'd15}, "R9 rev");
    for (int i = 0; i < 16; i++) begin
      run(4'd8, (16'h1 << i) | 16'h8000, 16'h0, 5'd0, 1'b0, "R8 fwd sweep");
      run(4'd9, (16'h1 << i) | 16'h0001, 16'h0, 5'd0, 1'b1, "R9 rev sweep");
    end
  endtask

  task automatic t_scan_zero();
    drive_expect(4'd8, 16'h0, 16'hBEEF, 5'd3, 1'b1, {2'b11, 16'hBEEF}, "R10 fwd zero");
    drive_expect(4'd9, 16'h0, 16'h1357, 5'd3, 1'b0, {2'b10, 16'h1357}, "R10 rev zero");
  endtask

  task automatic t_unused();
    for (int o = 10; o < 16; o++)
      drive_expect(4'(o), 16'hC3A5, 16'h1111, 5'd7, o[0], {1'b0, o[0], 16'hC3A5}, "R11 unused");
  endtask

  initial begin
    rst_n = 1'b0;
    op = 4'd0; opnd = 16'h0; dst = 16'h0; cnt = 5'd0; cin = 1'b0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    t_idle();
    t_plain_rot();
    t_carry_rot();
    t_zero_count();
    t_bit_ops();
    t_scans();
    t_scan_zero();
    t_unused();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule